// File: doc/BRIEF.md
# Smart Card Deactivation Sequencer

This block powers a contact smart card down in a safe, ordered way at the end of a session. It runs from a slow timing clock (1.5 MHz by default). The host holds an active-low session command low for the length of a session. The block then keeps the card supply on, the card clock running, the I/O line released in receive mode and the card reset high. The power-down runs when the host raises the session command. It also runs on its own when any synchronised fault flag rises during a session (over-current, over-temperature or supply fault) or when the card is pulled out. The power-down drops the card lines one at a time, with a minimum gap between steps. It then waits a discharge interval before it reports that it is idle.

A single active-low status output serves two purposes. Outside a session it reports whether a card is inserted. Inside a session it drops as soon as a fault or a removal is seen. After a fault-driven shutdown it stays low until the host raises the session command. This lets the host tell a fault shutdown apart from a shutdown it asked for.

Top module: `sc_deact_seq`

## Requirements
- R1: While reset is held and just after it is released, the card supply enable, card reset, card clock enable and I/O release are all 0, the idle flag `done_o` is 1 and `off_n_o` is 0.
- R2: Outside a session, `off_n_o` follows the card-presence input on the third rising edge after it changes (two synchroniser flops plus one output register). Fault flags have no effect on `off_n_o` or on the card lines.
- R3: A session starts on the next rising edge after `sess_cmd_n_i` goes low, provided the block is idle, the command has been seen high while idle, a card is synchronised as present and no fault is synchronised. At that edge the supply, clock enable, I/O release and reset all go to 1 and `done_o` goes to 0. A low command without that earlier high, including one held low through reset, starts nothing.
- R4: During a session, `sess_cmd_n_i` high starts the power-down on the next rising edge, and `off_n_o` keeps showing card presence.
- R5: During a session, a fault flag (bit 0 over-current, bit 1 over-temperature, bit 2 supply fault) or the loss of card presence starts the power-down on the third rising edge after the input changes. `off_n_o` falls on that same edge.
- R6: Once started, the power-down drops the lines in this order: card reset, then card clock enable, then I/O release, then card supply. The first step comes STEP edges after the start, and each later step STEP edges after the one before, where STEP = max(1, ceil(GAP_NS * CLK_KHZ / 1e6)).
- R7: `done_o` rises DIS_CYC edges after the supply enable falls. No session can start before that.
- R8: Changes to the session command or the fault and presence inputs during a power-down do not alter its timing. A command that goes high and then low again during the power-down does not arm a new session.
- R9: After a power-down caused by a fault or removal, `off_n_o` stays 0 until the block is idle and sees `sess_cmd_n_i` high. It then follows card presence again.
- R10: `done_o` is 1 only when the supply and all card lines are 0 and the discharge wait is over. It is 0 throughout a session and a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (default 1.5 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_cmd_n_i | input | 1 | Host session command, low = session wanted, high = release |
| card_present_i | input | 1 | Card presence detector, 1 = card inserted (asynchronous) |
| fault_i | input | NFLT | Fault flags (asynchronous): bit 0 over-current, bit 1 over-temperature, bit 2 supply fault |
| card_rst_o | output | 1 | Card reset line level |
| card_clk_en_o | output | 1 | Card clock run enable; 0 holds the card clock low |
| card_io_rel_o | output | 1 | 1 = I/O released in receive mode, 0 = I/O forced low |
| vcc_en_o | output | 1 | Card supply enable |
| off_n_o | output | 1 | Active-low status: card presence outside a session, fault indication inside one |
| done_o | output | 1 | Idle flag: supply off, lines low, discharge wait complete |

## Verification
Every cause of the power-down is run: the host release, each fault bit and card removal. Each run times every line drop to the exact edge. If the synchroniser were bypassed or doubled, or a step gap were off by one, the bench would see the shift. If two steps were swapped, an early line would fall late. The bench toggles the command and clears the fault in the middle of a power-down. A design that could be aborted would move the supply-off edge, and one that armed during the power-down would start a new session after idle. It also checks that the status output stays low after a fault until the command goes high, and that a command held low through reset starts nothing. A design that cleared the fault latch too early, or started from reset without arming, would show up there.

// File: rtl/sc_deact_pkg.sv
package sc_deact_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_DRST   = 3'd2,
        ST_DCLK   = 3'd3,
        ST_DIO    = 3'd4,
        ST_DVCC   = 3'd5,
        ST_DDIS   = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic rst;
        logic clk_en;
        logic io_rel;
        logic vcc_en;
    } card_lines_t;

    typedef struct packed {
        seq_state_e  state;
        logic        armed;
        logic        flt_lat;
        logic        off_n;
        card_lines_t lines;
        logic        done;
    } seq_regs_t;

    // Line levels held in each state; each power-down step clears one more line.
    function automatic card_lines_t lines_for(seq_state_e s);
        card_lines_t l;
        case (s)
            ST_ACTIVE, ST_DRST: l = '{rst: 1'b1, clk_en: 1'b1, io_rel: 1'b1, vcc_en: 1'b1};
            ST_DCLK:            l = '{rst: 1'b0, clk_en: 1'b1, io_rel: 1'b1, vcc_en: 1'b1};
            ST_DIO:             l = '{rst: 1'b0, clk_en: 1'b0, io_rel: 1'b1, vcc_en: 1'b1};
            ST_DVCC:            l = '{rst: 1'b0, clk_en: 1'b0, io_rel: 1'b0, vcc_en: 1'b1};
            default:            l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/sc_sync_vec.sv
module sc_sync_vec #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= 2'b00;
            else        stg_q <= {stg_q[0], d_i[i]};
        end
        assign q_o[i] = stg_q[1];
    end
endmodule

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    // Expires on the cycle the count reaches limit-1; saturates there.
    assign expired_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

    always_comb begin
        if (restart_i)      cnt_d = '0;
        else if (expired_o) cnt_d = cnt_q;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sc_deact_seq.sv
module sc_deact_seq
    import sc_deact_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 1500,
    parameter int unsigned GAP_NS  = 500,
    parameter int unsigned DIS_CYC = 150,
    parameter int unsigned NFLT    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sess_cmd_n_i,
    input  logic            card_present_i,
    input  logic [NFLT-1:0] fault_i,
    output logic            card_rst_o,
    output logic            card_clk_en_o,
    output logic            card_io_rel_o,
    output logic            vcc_en_o,
    output logic            off_n_o,
    output logic            done_o
);
    localparam longint unsigned STEP_RAW = (longint'(GAP_NS) * CLK_KHZ + 64'd999999) / 64'd1000000;
    localparam int unsigned STEP_CYC = (STEP_RAW < 1) ? 1 : int'(STEP_RAW);
    localparam int unsigned DIS_EFF  = (DIS_CYC < 1) ? 1 : DIS_CYC;
    localparam int unsigned MAX_CYC  = (STEP_CYC > DIS_EFF) ? STEP_CYC : DIS_EFF;
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    logic [NFLT:0]   sync_w;
    logic            present_s;
    logic [NFLT-1:0] flt_s;
    logic            tmr_exp;
    logic            tmr_restart;
    logic [CW-1:0]   tmr_limit;

    seq_regs_t st_d, st_q;

    sc_sync_vec #(.W(NFLT + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({card_present_i, fault_i}),
        .q_o   (sync_w)
    );

    assign present_s = sync_w[NFLT];
    assign flt_s     = sync_w[NFLT-1:0];

    sc_step_timer #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .limit_i   (tmr_limit),
        .expired_o (tmr_exp)
    );

    assign tmr_limit   = (st_q.state == ST_DDIS) ? CW'(DIS_EFF) : CW'(STEP_CYC);
    assign tmr_restart = (st_d.state != st_q.state);

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_IDLE: begin
                if (sess_cmd_n_i) begin
                    st_d.armed   = 1'b1;
                    st_d.flt_lat = 1'b0;
                end else if (st_q.armed && present_s && !(|flt_s)) begin
                    st_d.state = ST_ACTIVE;
                    st_d.armed = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if ((|flt_s) || !present_s) begin
                    st_d.state   = ST_DRST;
                    st_d.flt_lat = 1'b1;
                end else if (sess_cmd_n_i) begin
                    st_d.state = ST_DRST;
                end
            end
            ST_DRST: if (tmr_exp) st_d.state = ST_DCLK;
            ST_DCLK: if (tmr_exp) st_d.state = ST_DIO;
            ST_DIO:  if (tmr_exp) st_d.state = ST_DVCC;
            ST_DVCC: if (tmr_exp) st_d.state = ST_DDIS;
            ST_DDIS: if (tmr_exp) st_d.state = ST_IDLE;
            default: st_d.state = ST_IDLE;
        endcase
        st_d.lines = lines_for(st_d.state);
        st_d.done  = (st_d.state == ST_IDLE);
        st_d.off_n = !st_d.flt_lat && present_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.done  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_rst_o    = st_q.lines.rst;
    assign card_clk_en_o = st_q.lines.clk_en;
    assign card_io_rel_o = st_q.lines.io_rel;
    assign vcc_en_o      = st_q.lines.vcc_en;
    assign off_n_o       = st_q.off_n;
    assign done_o        = st_q.done;
endmodule

// File: rtl/sc_deact_seq_chk.sv
module sc_deact_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic card_rst,
    input logic card_clk_en,
    input logic card_io_rel,
    input logic vcc_en,
    input logic done
);
    p_clk_after_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk_en) |-> !card_rst);

    p_io_after_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_io_rel) |-> (!card_clk_en && !card_rst));

    p_vcc_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> (!card_io_rel && !card_clk_en && !card_rst));

    p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({$fell(card_rst), $fell(card_clk_en), $fell(card_io_rel), $fell(vcc_en)}) <= 1);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(vcc_en || card_rst || card_clk_en || card_io_rel));

    p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> ($past(done) && card_rst && card_clk_en && card_io_rel));

    p_done_after_vcc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(!vcc_en) && !vcc_en));
endmodule

bind sc_deact_seq sc_deact_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .card_rst    (card_rst_o),
    .card_clk_en (card_clk_en_o),
    .card_io_rel (card_io_rel_o),
    .vcc_en      (vcc_en_o),
    .done        (done_o)
);

// File: tb/sc_deact_seq_bench.sv
`timescale 1ns/1ps
module sc_deact_seq_bench;
    localparam int unsigned KHZ  = 1500;
    localparam int unsigned GAP  = 1500;
    localparam int unsigned DIS  = 20;
    localparam int unsigned NF   = 3;
    localparam int          S    = (GAP * KHZ + 999999) / 1000000; // 3 per R6
    localparam int          SYNC = 2;

    typedef struct packed {
        logic [2:0] cause;   // 0 host, 1..3 fault bit (cause-1), 4 removal
        logic [3:0] lat;
        logic       off_end;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{cause: 3'd0, lat: 4'd0,   off_end: 1'b1},
        '{cause: 3'd1, lat: 4'(SYNC), off_end: 1'b0},
        '{cause: 3'd2, lat: 4'(SYNC), off_end: 1'b0},
        '{cause: 3'd3, lat: 4'(SYNC), off_end: 1'b0},
        '{cause: 3'd4, lat: 4'(SYNC), off_end: 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sess_cmd_n = 1'b0;
    logic present = 1'b1;
    logic [NF-1:0] fault = '0;
    logic card_rst, card_clk_en, card_io_rel, vcc_en, off_n, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sc_deact_seq #(.CLK_KHZ(KHZ), .GAP_NS(GAP), .DIS_CYC(DIS), .NFLT(NF)) u_sc_deact_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .sess_cmd_n_i   (sess_cmd_n),
        .card_present_i (present),
        .fault_i        (fault),
        .card_rst_o     (card_rst),
        .card_clk_en_o  (card_clk_en),
        .card_io_rel_o  (card_io_rel),
        .vcc_en_o       (vcc_en),
        .off_n_o        (off_n),
        .done_o         (done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R3: arm with command high, then request a session
    task automatic activate(input string tag);
        sess_cmd_n = 1'b1;
        present    = 1'b1;
        fault      = '0;
        step(4);
        sess_cmd_n = 1'b0;
        step(1);
        check({tag, " R3 lines up"}, {card_rst, card_clk_en, card_io_rel, vcc_en}, 4'b1111);
        check({tag, " R10 done low in session"}, done, 0);
    endtask

    // Trigger a power-down and time every line drop (R4 R5 R6 R7 R8)
    task automatic run_deact(input vec_t v, input bit disturb, input string tag);
        int t_rst = 0, t_clk = 0, t_io = 0, t_vcc = 0, t_done = 0, t_off = 0;
        int lat = int'(v.lat);
        if (v.cause == 3'd0)      sess_cmd_n = 1'b1;
        else if (v.cause == 3'd4) present = 1'b0;
        else                      fault[v.cause - 3'd1] = 1'b1;
        for (int c = 1; c <= 60; c++) begin
            step(1);
            if (t_rst == 0 && !card_rst)    t_rst  = c;
            if (t_clk == 0 && !card_clk_en) t_clk  = c;
            if (t_io == 0 && !card_io_rel)  t_io   = c;
            if (t_vcc == 0 && !vcc_en)      t_vcc  = c;
            if (t_done == 0 && done)        t_done = c;
            if (t_off == 0 && !off_n)       t_off  = c;
            if (c == lat + 4 * S)   check({tag, " R10 done low while supply on"}, done, 0);
            if (disturb && c == 4) begin fault = '0; sess_cmd_n = 1'b1; end
            if (disturb && c == 6) sess_cmd_n = 1'b0;
        end
        check({tag, " R6 reset falls"},     t_rst, lat + S + 1);
        check({tag, " R6 clock stops"},     t_clk, lat + 2 * S + 1);
        check({tag, " R6 io forced low"},   t_io,  lat + 3 * S + 1);
        check({tag, " R6 supply off"},      t_vcc, lat + 4 * S + 1);
        check({tag, " R7 done after wait"}, t_done, lat + 4 * S + DIS + 1);
        if (v.off_end) check({tag, " R4 off_n tracks presence"}, t_off, 0);
        else           check({tag, " R5 off_n falls at start"}, t_off, lat + 1);
        check({tag, " R9 off_n at end"}, off_n, int'(v.off_end));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state, command held low and card present through reset
        step(3);
        check("R1 lines in reset", {card_rst, card_clk_en, card_io_rel, vcc_en}, 0);
        check("R1 done in reset", done, 1);
        check("R1 off_n in reset", off_n, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 done after release", done, 1);
        // R3: no session without the command first seen high
        step(8);
        check("R3 no start unarmed", vcc_en, 0);
        check("R2 off_n shows card present", off_n, 1);

        // R2: presence tracking latency, faults ignored outside a session
        sess_cmd_n = 1'b1;
        present = 1'b0;
        step(2);
        check("R2 off_n before sync", off_n, 1);
        step(1);
        check("R2 off_n after sync", off_n, 0);
        present = 1'b1;
        step(3);
        check("R2 off_n back", off_n, 1);
        fault = 3'b111;
        step(5);
        check("R2 fault ignored off_n", off_n, 1);
        check("R2 fault ignored supply", vcc_en, 0);
        fault = '0;
        step(3);

        // Vector walk over every shutdown cause
        foreach (VECS[k]) begin
            activate($sformatf("vec%0d", k));
            run_deact(VECS[k], 1'b0, $sformatf("vec%0d", k));
            fault = '0;
            present = 1'b1;
            step(4);
            if (!VECS[k].off_end) check($sformatf("vec%0d R9 off_n held", k), off_n, 0);
            sess_cmd_n = 1'b1;
            step(2);
            check($sformatf("vec%0d R9 off_n released", k), off_n, 1);
        end

        // R8: disturbances during the power-down change nothing
        activate("abort");
        run_deact('{cause: 3'd1, lat: 4'(SYNC), off_end: 1'b0}, 1'b1, "abort R8");
        step(10);
        check("R8 no rearm from mid-sequence command", vcc_en, 0);
        check("R9 off_n still low", off_n, 0);
        sess_cmd_n = 1'b1;
        step(2);
        check("R9 off_n after command high", off_n, 1);

        // R3: session refused while a fault is present
        fault = 3'b100;
        step(3);
        sess_cmd_n = 1'b0;
        step(4);
        check("R3 no start with fault", vcc_en, 0);
        fault = '0;
        sess_cmd_n = 1'b1;
        step(4);
        summary();
    end
endmodule